// File: doc/BRIEF.md
# SAR Conversion Sequencer

This block is the cycle-level control model of a successive-approximation converter, clocked from the system clock. A falling edge on the active-low start input opens a conversion. The block raises `busy`, counts down a conversion time that depends on the selected speed, takes the word on `sample_in` into the result register, and then drops `busy`. A one-cycle `data_ready` strobe marks the moment the new result is available. An acquisition window follows during which the sampler settles. Start edges that arrive in that window are dropped.

Two speed pins select one of three conversion speeds. The fastest speed has a redundant-free code, and the slowest-but-one (normal) is reachable from two codes. All time intervals are given in nanoseconds and turned into cycle counts from a clock-frequency parameter. Only the fast speed limits how far apart starts may be. Exceeding that limit raises a sticky flag. A power-down input blocks new starts but lets a running conversion finish. A reset input aborts everything and clears the result.

Top module: `sar_conv_sequencer`

## Requirements
- R1: A start edge (`cnv_start_n` sampled high on one clock edge and low on the next) while idle and with `power_down` low makes `busy` high right after that clock edge.
- R2: `speed_sel` is decoded as {fast pin, slow pin}. 2'b10 selects warp (1100 ns), 2'b01 selects impulse (1500 ns), and 2'b00 and 2'b11 both select normal (1300 ns). Each time is rounded up to whole clock cycles (110, 130 and 150 cycles at 100 MHz). `busy` stays high for exactly that many cycles.
- R3: On the clock edge where `busy` falls, `result` takes the value on `sample_in`. `data_ready` is high for exactly the one cycle in which `busy` is first low.
- R4: The speed is captured at the start edge. Changing `speed_sel` during a conversion does not change its length.
- R5: After `busy` falls, an acquisition window of 310 ns (31 cycles at 100 MHz) follows. The acquisition window includes its last cycle. A start edge during `busy` or during this window starts nothing and increments `ignored_count` by one.
- R6: A conversion already running when `power_down` rises completes normally. A start edge seen while idle with `power_down` high starts nothing and leaves `ignored_count` unchanged.
- R7: While `reset` is high, the following outputs are all zero from the next clock edge: `busy`, `data_ready`, `result`, `ignored_count` and `spacing_err`. A conversion in progress is abandoned, and `result` is still zero after release.
- R8: `spacing_err` is set when an accepted warp-speed start comes more than the limit (`WARP_GAP_NS`, rounded up to cycles) after the previous accepted start of any speed. A gap equal to the limit does not set it. Normal or impulse starts never set it, and neither does the first start after reset. Once set, the flag stays set until reset.
- R9: `result` keeps its value between conversions, whatever `sample_in` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| reset | input | 1 | Synchronous active-high reset; aborts conversion |
| cnv_start_n | input | 1 | Conversion start; falling edge requests a conversion |
| speed_sel | input | 2 | Speed pins {fast, slow} |
| power_down | input | 1 | High blocks new conversions |
| sample_in | input | DATA_W (18) | Converted value to be latched |
| busy | output | 1 | High while a conversion runs |
| data_ready | output | 1 | One-cycle strobe when a new result is latched |
| result | output | DATA_W (18) | Latched conversion result |
| ignored_count | output | IGN_W (8) | Start edges dropped during busy or acquisition |
| spacing_err | output | 1 | Sticky warp-speed spacing violation |

## Verification
The two hardest situations to reach from the ports are exact timing boundaries. One is a start edge that lands on the final cycle of the acquisition window. The other is a pair of warp starts spaced at exactly the limit, and then at one cycle beyond it. The stimulus reaches both by counting idle cycles from the known conversion and acquisition lengths. A cycle-stamped model of accepted starts in the bench decides whether the flag is expected. Randomised speeds, data, idle gaps and mid-conversion disturbances are run in between.

// File: rtl/sarseq_pkg.sv
package sarseq_pkg;

   typedef enum logic [1:0] {
      SPD_NORMAL  = 2'd0,
      SPD_IMPULSE = 2'd1,
      SPD_WARP    = 2'd2
   } speed_t;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_CONV = 2'd1,
      ST_ACQ  = 2'd2
   } seq_state_t;

   // nanoseconds to clock cycles, rounded up
   function automatic int unsigned ns_to_cycles(input int unsigned ns, input int unsigned mhz);
      return (ns * mhz + 999) / 1000;
   endfunction

endpackage

// File: rtl/sarseq_speed_decode.sv
module sarseq_speed_decode
   import sarseq_pkg::*;
#(
   parameter int unsigned TW       = 8,
   parameter int unsigned WARP_CYC = 110,
   parameter int unsigned NORM_CYC = 130,
   parameter int unsigned IMP_CYC  = 150
) (
   input  logic [1:0]    speed_pins,
   output speed_t        speed,
   output logic [TW-1:0] conv_load
);

   always_comb begin
      unique case (speed_pins)
         2'b10: begin
            speed     = SPD_WARP;
            conv_load = TW'(WARP_CYC - 1);
         end
         2'b01: begin
            speed     = SPD_IMPULSE;
            conv_load = TW'(IMP_CYC - 1);
         end
         default: begin
            // 00 and 11 both give normal speed
            speed     = SPD_NORMAL;
            conv_load = TW'(NORM_CYC - 1);
         end
      endcase
   end

endmodule

// File: rtl/sarseq_timer.sv
module sarseq_timer #(
   parameter int unsigned TW = 8
) (
   input  logic          clk,
   input  logic          reset,
   input  logic          load,
   input  logic [TW-1:0] load_val,
   output logic          expired
);

   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (reset)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - TW'(1);
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/sarseq_gap_check.sv
module sarseq_gap_check #(
   parameter int unsigned GAP_CYC = 1000,
   parameter int unsigned GW      = $clog2(GAP_CYC + 2)
) (
   input  logic clk,
   input  logic reset,
   input  logic start,
   input  logic start_warp,
   output logic err
);

   logic [GW-1:0] gap_q;
   logic          have_prev_q;

   always_ff @(posedge clk) begin
      if (reset) begin
         gap_q       <= '0;
         have_prev_q <= 1'b0;
         err         <= 1'b0;
      end else if (start) begin
         if (have_prev_q && start_warp && (gap_q > GW'(GAP_CYC)))
            err <= 1'b1;
         gap_q       <= GW'(1);
         have_prev_q <= 1'b1;
      end else if (gap_q <= GW'(GAP_CYC)) begin
         gap_q <= gap_q + GW'(1);   // saturates one past the limit
      end
   end

   assert_err_sticky_R8: assert property (@(posedge clk) disable iff (reset)
      err |=> err);

   assert_slow_no_err_R8: assert property (@(posedge clk) disable iff (reset)
      (start && !start_warp && !err) |=> !err);

endmodule

// File: rtl/sar_conv_sequencer.sv
module sar_conv_sequencer
   import sarseq_pkg::*;
#(
   parameter int unsigned DATA_W      = 18,
   parameter int unsigned CLK_MHZ     = 100,
   parameter int unsigned WARP_NS     = 1100,
   parameter int unsigned NORMAL_NS   = 1300,
   parameter int unsigned IMPULSE_NS  = 1500,
   parameter int unsigned ACQ_NS      = 310,
   parameter int unsigned WARP_GAP_NS = 1_000_000,
   parameter int unsigned IGN_W       = 8,
   parameter bit          SYNC_START  = 1'b0
) (
   input  logic              clk,
   input  logic              reset,
   input  logic              cnv_start_n,
   input  logic [1:0]        speed_sel,
   input  logic              power_down,
   input  logic [DATA_W-1:0] sample_in,
   output logic              busy,
   output logic              data_ready,
   output logic [DATA_W-1:0] result,
   output logic [IGN_W-1:0]  ignored_count,
   output logic              spacing_err
);

   localparam int unsigned WARP_CYC = ns_to_cycles(WARP_NS, CLK_MHZ);
   localparam int unsigned NORM_CYC = ns_to_cycles(NORMAL_NS, CLK_MHZ);
   localparam int unsigned IMP_CYC  = ns_to_cycles(IMPULSE_NS, CLK_MHZ);
   localparam int unsigned ACQ_CYC  = ns_to_cycles(ACQ_NS, CLK_MHZ);
   localparam int unsigned GAP_CYC  = ns_to_cycles(WARP_GAP_NS, CLK_MHZ);
   localparam int unsigned MAX_A    = (WARP_CYC > NORM_CYC) ? WARP_CYC : NORM_CYC;
   localparam int unsigned MAX_B    = (IMP_CYC > ACQ_CYC) ? IMP_CYC : ACQ_CYC;
   localparam int unsigned MAX_CYC  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int unsigned TW       = $clog2(MAX_CYC + 1);
   localparam int unsigned GW       = $clog2(GAP_CYC + 2);

   // elaboration-time parameter checks
   if (DATA_W == 0 || IGN_W == 0) begin : g_bad_width
      $error("sar_conv_sequencer: DATA_W and IGN_W must be non-zero");
   end
   if (WARP_CYC < 1 || NORM_CYC < 1 || IMP_CYC < 1 || ACQ_CYC < 1) begin : g_bad_time
      $error("sar_conv_sequencer: every interval must span at least one cycle");
   end
   if (GAP_CYC <= WARP_CYC) begin : g_bad_gap
      $error("sar_conv_sequencer: spacing limit shorter than a conversion");
   end

   // start input conditioning: direct or two-flop synchronised
   logic start_lvl;
   if (SYNC_START) begin : g_sync
      logic [1:0] sync_q;
      always_ff @(posedge clk) begin
         if (reset) sync_q <= 2'b11;
         else       sync_q <= {sync_q[0], cnv_start_n};
      end
      assign start_lvl = sync_q[1];
   end else begin : g_direct
      assign start_lvl = cnv_start_n;
   end

   logic start_prev_q;
   always_ff @(posedge clk) begin
      if (reset) start_prev_q <= 1'b1;
      else       start_prev_q <= start_lvl;
   end

   logic start_fall;
   assign start_fall = start_prev_q & ~start_lvl;

   // speed decode
   speed_t        speed;
   logic [TW-1:0] conv_load;

   sarseq_speed_decode #(
      .TW       (TW),
      .WARP_CYC (WARP_CYC),
      .NORM_CYC (NORM_CYC),
      .IMP_CYC  (IMP_CYC)
   ) u_decode (
      .speed_pins (speed_sel),
      .speed      (speed),
      .conv_load  (conv_load)
   );

   // sequencing
   seq_state_t    state_q;
   logic          accept;
   logic          t_expired;
   logic          t_load;
   logic [TW-1:0] t_load_val;

   assign accept     = start_fall && (state_q == ST_IDLE) && !power_down;
   assign t_load     = accept || ((state_q == ST_CONV) && t_expired);
   assign t_load_val = accept ? conv_load : TW'(ACQ_CYC - 1);

   sarseq_timer #(.TW(TW)) u_timer (
      .clk      (clk),
      .reset    (reset),
      .load     (t_load),
      .load_val (t_load_val),
      .expired  (t_expired)
   );

   always_ff @(posedge clk) begin
      if (reset) begin
         state_q       <= ST_IDLE;
         busy          <= 1'b0;
         data_ready    <= 1'b0;
         result        <= '0;
         ignored_count <= '0;
      end else begin
         data_ready <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  state_q <= ST_CONV;
                  busy    <= 1'b1;
               end
            end
            ST_CONV: begin
               if (t_expired) begin
                  result     <= sample_in;
                  busy       <= 1'b0;
                  data_ready <= 1'b1;
                  state_q    <= ST_ACQ;
               end
            end
            ST_ACQ: begin
               if (t_expired) state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
         if (start_fall && (state_q != ST_IDLE) && (ignored_count != '1))
            ignored_count <= ignored_count + IGN_W'(1);
      end
   end

   sarseq_gap_check #(
      .GAP_CYC (GAP_CYC),
      .GW      (GW)
   ) u_gap (
      .clk        (clk),
      .reset      (reset),
      .start      (accept),
      .start_warp (speed == SPD_WARP),
      .err        (spacing_err)
   );

   // assertions
   assert_busy_rise_R1: assert property (@(posedge clk) disable iff (reset)
      accept |=> busy);

   assert_pd_block_R6: assert property (@(posedge clk) disable iff (reset)
      (start_fall && (state_q == ST_IDLE) && power_down) |=> !busy);

   assert_ready_at_fall_R3: assert property (@(posedge clk) disable iff (reset)
      ($fell(busy) && !$past(reset)) |-> data_ready);

   assert_ready_single_R3: assert property (@(posedge clk) disable iff (reset)
      data_ready |=> !data_ready);

   assert_result_hold_R9: assert property (@(posedge clk) disable iff (reset)
      (!data_ready && !$past(reset)) |-> $stable(result));

   assert_ignore_count_R5: assert property (@(posedge clk) disable iff (reset)
      (start_fall && (state_q != ST_IDLE) && (ignored_count != '1))
      |=> (ignored_count == $past(ignored_count) + IGN_W'(1)));

   assert_reset_clear_R7: assert property (@(posedge clk)
      reset |=> (!busy && !data_ready && (result == '0) &&
                 (ignored_count == '0) && !spacing_err));

endmodule

// File: tb/sar_conv_sequencer_test.sv
module sar_conv_sequencer_test;

   localparam int CLK_PERIOD = 10;
   localparam int DW         = 18;
   localparam int MHZ        = 100;
   localparam int GAP_NS     = 5000;

   function automatic int cyc_of(input int ns);
      return (ns * MHZ + 999) / 1000;
   endfunction

   function automatic int exp_len(input logic [1:0] sel);
      if (sel == 2'b10)      return cyc_of(1100);
      else if (sel == 2'b01) return cyc_of(1500);
      else                   return cyc_of(1300);
   endfunction

   localparam int ACQ_C = (310 * MHZ + 999) / 1000;
   localparam int GAP_C = (GAP_NS * MHZ + 999) / 1000;

   logic          clk;
   logic          reset;
   logic          cnv_start_n;
   logic [1:0]    speed_sel;
   logic          power_down;
   logic [DW-1:0] sample_in;
   logic          busy;
   logic          data_ready;
   logic [DW-1:0] result;
   logic [7:0]    ignored_count;
   logic          spacing_err;

   sar_conv_sequencer #(
      .DATA_W      (DW),
      .CLK_MHZ     (MHZ),
      .WARP_GAP_NS (GAP_NS)
   ) uut (
      .clk           (clk),
      .reset         (reset),
      .cnv_start_n   (cnv_start_n),
      .speed_sel     (speed_sel),
      .power_down    (power_down),
      .sample_in     (sample_in),
      .busy          (busy),
      .data_ready    (data_ready),
      .result        (result),
      .ignored_count (ignored_count),
      .spacing_err   (spacing_err)
   );

   initial begin
      clk = 1'b0;
      forever #(CLK_PERIOD / 2) clk = ~clk;
   end

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int errors = 0;
   int checks = 0;

   // bench model
   int  exp_ign    = 0;
   bit  exp_err    = 1'b0;
   bit  have_prev  = 1'b0;
   int  last_start = 0;

   task automatic chk(input string req, input string what,
                      input longint unsigned act, input longint unsigned exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic note_start(input logic [1:0] sel);
      int gap;
      gap = cyc - last_start;
      if (have_prev && sel == 2'b10 && gap > GAP_C) exp_err = 1'b1;
      have_prev  = 1'b1;
      last_start = cyc;
   endtask

   // caller is at a negedge with the block idle
   task automatic convert(input logic [1:0] sel, input logic [DW-1:0] val,
                          input bit mid_pulse, input bit mid_swap,
                          input bit pd_mid, input bit late_pulse);
      int n;
      speed_sel   = sel;
      sample_in   = val;
      cnv_start_n = 1'b0;
      @(negedge clk);
      cnv_start_n = 1'b1;
      note_start(sel);
      chk("R1", "busy after start edge", busy, 1);
      n = 1;
      forever begin
         if (n == 2 && pd_mid) power_down = 1'b1;
         if (n == 3 && mid_swap) speed_sel = ~sel;          // R4
         if (n == 5 && mid_pulse) cnv_start_n = 1'b0;
         if (n == 6 && mid_pulse) begin
            cnv_start_n = 1'b1;
            exp_ign++;
         end
         @(negedge clk);
         if (!busy) break;
         n++;
      end
      chk("R2", "busy length", n, exp_len(sel));
      chk("R4", "length unaffected by speed change", n, exp_len(sel));
      chk("R3", "data_ready at busy fall", data_ready, 1);
      chk("R3", "result latched", result, val);
      sample_in = ~val;
      speed_sel = sel;
      @(negedge clk);
      chk("R3", "data_ready one cycle", data_ready, 0);
      if (late_pulse) begin
         repeat (ACQ_C - 2) @(negedge clk);
         cnv_start_n = 1'b0;                       // edge on last acquisition cycle
         @(negedge clk);
         cnv_start_n = 1'b1;
         exp_ign++;
         chk("R5", "no start on last acquisition cycle", busy, 0);
         @(negedge clk);
      end else begin
         repeat (ACQ_C - 1) @(negedge clk);
      end
      chk("R9", "result held", result, val);
      chk("R5", "ignored_count", ignored_count, exp_ign);
      chk("R8", "spacing_err", spacing_err, exp_err);
   endtask

   task automatic summary;
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=0", 1);
      summary();
      $finish;
   end

   initial begin
      int unsigned seed_dummy;
      seed_dummy  = $urandom(32'd20240613);
      reset       = 1'b1;
      cnv_start_n = 1'b1;
      speed_sel   = 2'b00;
      power_down  = 1'b0;
      sample_in   = '0;
      repeat (3) @(negedge clk);
      reset = 1'b0;
      @(negedge clk);
      chk("R7", "reset busy", busy, 0);
      chk("R7", "reset data_ready", data_ready, 0);
      chk("R7", "reset result", result, 0);
      chk("R7", "reset ignored_count", ignored_count, 0);
      chk("R7", "reset spacing_err", spacing_err, 0);

      // each speed code, including the redundant normal code
      convert(2'b00, 18'h2A5A5, 0, 0, 0, 0);
      convert(2'b11, 18'h15A5A, 0, 0, 0, 0);
      convert(2'b01, 18'h3FFFF, 0, 0, 0, 0);
      convert(2'b10, 18'h00001, 0, 0, 0, 0);
      // ignored edge during busy (R5), speed change mid conversion (R4)
      convert(2'b10, 18'h12345, 1, 0, 0, 0);
      convert(2'b01, 18'h0F0F0, 0, 1, 0, 0);
      convert(2'b10, 18'h20000, 0, 1, 0, 0);
      // edge on final acquisition cycle (R5)
      convert(2'b00, 18'h3C3C3, 0, 0, 0, 1);

      // power-down mid conversion, then an idle start edge (R6)
      convert(2'b00, 18'h11111, 0, 0, 1, 0);
      cnv_start_n = 1'b0;
      @(negedge clk);
      cnv_start_n = 1'b1;
      chk("R6", "start blocked by power_down", busy, 0);
      @(negedge clk);
      chk("R6", "blocked start not counted", ignored_count, exp_ign);
      chk("R6", "still idle", busy, 0);
      power_down = 1'b0;
      @(negedge clk);

      // long gap with non-warp starts never flags (R8)
      convert(2'b00, 18'h0AAAA, 0, 0, 0, 0);
      repeat (GAP_C + 100) @(negedge clk);
      convert(2'b01, 18'h05555, 0, 0, 0, 0);
      chk("R8", "slow start after long gap", spacing_err, 0);

      // warp spacing exactly at the limit, then one cycle past it (R8)
      convert(2'b10, 18'h01010, 0, 0, 0, 0);
      repeat (GAP_C - (exp_len(2'b10) + ACQ_C) - 1) @(negedge clk);
      convert(2'b10, 18'h02020, 0, 0, 0, 0);
      chk("R8", "gap equal to limit", spacing_err, 0);
      repeat (GAP_C - (exp_len(2'b10) + ACQ_C)) @(negedge clk);
      convert(2'b10, 18'h03030, 0, 0, 0, 0);
      chk("R8", "gap one past limit", spacing_err, 1);
      convert(2'b00, 18'h04040, 0, 0, 0, 0);
      chk("R8", "flag sticky", spacing_err, 1);

      // randomised run
      for (int i = 0; i < 25; i++) begin
         logic [1:0]    rs;
         logic [DW-1:0] rv;
         rs = 2'($urandom_range(0, 3));
         rv = DW'($urandom);
         convert(rs, rv, bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)), 0, 0);
         repeat ($urandom_range(0, 30)) @(negedge clk);
      end

      // reset during a conversion (R7)
      speed_sel   = 2'b00;
      cnv_start_n = 1'b0;
      @(negedge clk);
      cnv_start_n = 1'b1;
      repeat (20) @(negedge clk);
      chk("R7", "busy before abort", busy, 1);
      reset = 1'b1;
      @(negedge clk);
      chk("R7", "abort busy", busy, 0);
      chk("R7", "abort result", result, 0);
      chk("R7", "abort ignored_count", ignored_count, 0);
      chk("R7", "abort spacing_err", spacing_err, 0);
      @(negedge clk);
      reset = 1'b0;
      exp_ign   = 0;
      exp_err   = 1'b0;
      have_prev = 1'b0;
      repeat (200) @(negedge clk);
      chk("R7", "result zero after release", result, 0);
      chk("R7", "no conversion resumed", busy, 0);
      // first warp start after reset never flags
      convert(2'b10, 18'h2BEEF, 0, 0, 0, 0);
      chk("R8", "first start after reset", spacing_err, 0);

      summary();
      $finish;
   end

endmodule